// File: doc/BRIEF.md
# Dual-Edge Interrupt GPIO for a Card Socket

This block is a general-purpose I/O unit with one bit per pin and a small register interface. Software picks a direction and an output value for every pin. It reads back the synchronised input levels. It can arm each pin to report rising edges, falling edges, or both. Rising and falling events go into two separate status banks. Software acknowledges a status bit by writing a 1 to it.

The unit watches the pins of a removable-card socket. Two of the inputs are active-low detect pins and one is an active-low ready pin.
- A falling edge on the ready pin raises the card-function interrupt.
- A falling edge on the second detect pin raises the card-status-change interrupt.
- An event register reports the pending socket event, and a ready event takes precedence over a detect event.
- A presence flag is high when both detect pins are low.

Host data is exchanged in swapped byte order: the low host byte carries the high register byte, and the reverse.

Top module: `gpio_evt_top`

## Requirements
- R1: After synchronous reset, every register reads 0 and `pin_oe`, `pin_out`, `card_irq`, `csc_irq` and `card_present` are 0.
- R2: Host data is byte-swapped on every read and write: bus bits [7:0] hold register bits [15:8] and bus bits [15:8] hold register bits [7:0]. Offset 0 is the direction register, which drives `pin_oe`, and offset 1 is the output register, which drives `pin_out`.
- R3: A read of offset 2 returns the pin levels after a two-flop synchroniser.
- R4: A synchronised rising edge on a pin sets that pin's bit in the rising-status register (offset 5) only when the same bit of the rising-enable register (offset 3) is 1.
- R5: A synchronised falling edge sets the falling-status register (offset 6) bit only when the same bit of the falling-enable register (offset 4) is 1.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: An edge that arrives in the same cycle as a clearing write keeps the status bit set.
- R8: `card_irq` is the level of falling status AND enable on the ready pin (bit 1). `csc_irq` is the same level on the second detect pin (bit 3). Both are registered.
- R9: Offset 7 bits [1:0] hold the event code: 1 means a ready event is pending, 2 means a detect event is pending, and 0 means neither is pending. When both are pending, the code is 1.
- R10: `card_present` is 1 only when the synchronised first detect pin (bit 2) and second detect pin (bit 3) are both 0.
- R11: Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled. Writes to offsets 2 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | PIN_W | Write data, byte-swapped |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | PIN_W | Read data, byte-swapped, one cycle late |
| pin_in | input | PIN_W | Asynchronous pin levels |
| pin_out | output | PIN_W | Output register value |
| pin_oe | output | PIN_W | Direction register, 1 = drive |
| card_irq | output | 1 | Card-function interrupt level |
| csc_irq | output | 1 | Card-status-change interrupt level |
| card_present | output | 1 | Both detect pins low |

## Verification
The bench builds the block with its default parameters:
- 16 pins, so the byte swap exercises two full bytes.
- Two synchroniser stages.
- Ready, first-detect and second-detect pins on bits 1, 2 and 3.

With these values the bench can reproduce both interrupt sources and the case where both events are pending at once. It can also check the presence flag with one detect pin still high. A timed stimulus lines up a synchronised rising edge exactly with a clearing write, which exposes the edge-over-clear rule.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR     = 3'd0,
    OFS_OUT     = 3'd1,
    OFS_IN      = 3'd2,
    OFS_RISE_EN = 3'd3,
    OFS_FALL_EN = 3'd4,
    OFS_RISE_ST = 3'd5,
    OFS_FALL_ST = 3'd6,
    OFS_EVENT   = 3'd7
  } reg_ofs_e;

  typedef enum logic [1:0] {
    EVT_NONE   = 2'd0,
    EVT_READY  = 2'd1,
    EVT_DETECT = 2'd2
  } evt_code_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic         en_wr,
  input  logic         st_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] st_q
);
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  assign set_v = hit & en_q;
  assign clr_v = st_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata;
      st_q <= (st_q & ~clr_v) | set_v;
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((st_q & $past(clr_v & ~set_v)) == '0)); // R6
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~$past(st_q) & ~$past(en_q)) == '0)); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (($past(set_v) & ~st_q) == '0)); // R7
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RDY_BIT     = 1,
  parameter int DET1_BIT    = 2,
  parameter int DET2_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              card_irq,
  output logic              csc_irq,
  output logic              card_present
);
  localparam int NBYTES = PIN_W / 8;

  function automatic logic [PIN_W-1:0] bswap(input logic [PIN_W-1:0] x);
    for (int b = 0; b < NBYTES; b++) bswap[b*8 +: 8] = x[(NBYTES-1-b)*8 +: 8];
  endfunction

  logic [PIN_W-1:0] wr_val;
  logic [PIN_W-1:0] sync_v;
  logic [PIN_W-1:0] prev_q;
  logic [PIN_W-1:0] rise_hit, fall_hit;
  logic [PIN_W-1:0] rise_en, rise_st, fall_en, fall_st;
  logic             ready_pend, det_pend;
  evt_code_e        evt_code;
  logic [PIN_W-1:0] rd_mux;

  assign wr_val = bswap(bus_wdata);

  gpio_evt_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(sync_v)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_v;
  end

  assign rise_hit = sync_v & ~prev_q;
  assign fall_hit = ~sync_v & prev_q;

  gpio_evt_bank #(.W(PIN_W)) u_rise (
    .clk(clk), .rst(rst), .hit(rise_hit),
    .en_wr(bus_wr && bus_addr == OFS_RISE_EN),
    .st_wr(bus_wr && bus_addr == OFS_RISE_ST),
    .wdata(wr_val), .en_q(rise_en), .st_q(rise_st)
  );

  gpio_evt_bank #(.W(PIN_W)) u_fall (
    .clk(clk), .rst(rst), .hit(fall_hit),
    .en_wr(bus_wr && bus_addr == OFS_FALL_EN),
    .st_wr(bus_wr && bus_addr == OFS_FALL_ST),
    .wdata(wr_val), .en_q(fall_en), .st_q(fall_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_DIR) pin_oe  <= wr_val;
      if (bus_addr == OFS_OUT) pin_out <= wr_val;
    end
  end

  assign ready_pend = fall_st[RDY_BIT] & fall_en[RDY_BIT];
  assign det_pend   = fall_st[DET2_BIT] & fall_en[DET2_BIT];

  always_comb begin
    if (ready_pend)    evt_code = EVT_READY;
    else if (det_pend) evt_code = EVT_DETECT;
    else               evt_code = EVT_NONE;
  end

  always_comb begin
    case (bus_addr)
      OFS_DIR:     rd_mux = pin_oe;
      OFS_OUT:     rd_mux = pin_out;
      OFS_IN:      rd_mux = sync_v;
      OFS_RISE_EN: rd_mux = rise_en;
      OFS_FALL_EN: rd_mux = fall_en;
      OFS_RISE_ST: rd_mux = rise_st;
      OFS_FALL_ST: rd_mux = fall_st;
      default:     rd_mux = {{(PIN_W-2){1'b0}}, evt_code};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      card_irq     <= 1'b0;
      csc_irq      <= 1'b0;
      card_present <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= bswap(rd_mux);
      card_irq     <= ready_pend;
      csc_irq      <= det_pend;
      card_present <= ~sync_v[DET1_BIT] & ~sync_v[DET2_BIT];
    end
  end

  AST_READY_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ready_pend && bus_rd && bus_addr == OFS_EVENT)
      |=> (bus_rdata == bswap({{(PIN_W-2){1'b0}}, EVT_READY}))); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(card_irq) |-> $past(fall_en[RDY_BIT])); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R11
endmodule

// File: tb/gpio_evt_top_test.sv
module gpio_evt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = 16'h000E;
  logic [W-1:0] pin_out, pin_oe;
  logic         card_irq, csc_irq, card_present;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_pending = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .card_irq(card_irq), .csc_irq(csc_irq), .card_present(card_present)
  );

  function automatic logic [W-1:0] hswap(input logic [W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] v);
    wr_raw(a, hswap(v));
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(hswap(exp));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_pending <= bus_rd;

  always @(negedge clk) begin
    if (rd_pending) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R11: unexpected read data %h expected none", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(4);
    chk(W'(card_present), 0, "R1 card_present");
    chk(W'(card_irq), 0, "R1 card_irq");
    chk(W'(csc_irq), 0, "R1 csc_irq");
    chk(pin_oe, 0, "R1 pin_oe");
    chk(pin_out, 0, "R1 pin_out");
    rd(3'd6, 16'h0000, "R1 fall status");
    rd(3'd3, 16'h0000, "R1 rise enable");

    wr(3'd0, 16'h00F1);
    chk(pin_oe, 16'h00F1, "R2 pin_oe");
    rd(3'd0, 16'h00F1, "R2 direction readback");
    wr_raw(3'd1, 16'h0012);
    chk(pin_out, 16'h1200, "R2 swapped write");
    rd(3'd1, 16'h1200, "R2 swapped read");

    rd(3'd2, 16'h000E, "R3 data in");

    wr(3'd3, 16'h0100);
    pin_in = 16'h030E;
    idle(5);
    rd(3'd5, 16'h0100, "R4 rise gated by enable");

    wr(3'd5, 16'h0000);
    rd(3'd5, 16'h0100, "R6 write 0 keeps");
    wr(3'd5, 16'h0100);
    rd(3'd5, 16'h0000, "R6 write 1 clears");

    pin_in = 16'h000E;
    idle(5);
    rd(3'd6, 16'h0000, "R5 fall without enable");

    pin_in[8] = 1'b1; idle(5);
    pin_in[8] = 1'b0; idle(5);
    @(negedge clk) pin_in[8] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = hswap(16'h0100); end
    @(negedge clk) bus_wr = 1'b0;
    idle(3);
    rd(3'd5, 16'h0100, "R7 edge beats clear");

    wr(3'd4, 16'h000A);
    pin_in = 16'h010C;
    idle(5);
    chk(W'(card_irq), 1, "R8 card_irq on ready fall");
    chk(W'(csc_irq), 0, "R8 csc_irq idle");
    rd(3'd7, 16'h0001, "R9 ready code");
    rd(3'd6, 16'h0002, "R5 fall status");

    pin_in = 16'h0100;
    idle(5);
    chk(W'(csc_irq), 1, "R8 csc_irq on detect fall");
    chk(W'(card_present), 1, "R10 both detect low");
    rd(3'd7, 16'h0001, "R9 ready before detect");
    rd(3'd6, 16'h000A, "R5 fall status gated");

    wr(3'd6, 16'h0002);
    idle(2);
    chk(W'(card_irq), 0, "R6 card_irq after clear");
    rd(3'd7, 16'h0002, "R9 detect code");

    pin_in = 16'h0104;
    idle(5);
    chk(W'(card_present), 0, "R10 one detect high");

    wr(3'd6, 16'h0008);
    idle(2);
    chk(W'(csc_irq), 0, "R6 csc_irq after clear");
    rd(3'd7, 16'h0000, "R9 no event");

    wr(3'd2, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd2, 16'h0104, "R11 data in write ignored");
    rd(3'd7, 16'h0000, "R11 event write ignored");
    rd(3'd0, 16'h00F1, "R11 direction untouched");

    idle(3);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL R11: actual %0d reads outstanding expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule